// File: doc/BRIEF.md
# Midplane Interrupt Aggregation Registers

This block is a small register file that sits on a router midplane. It gives the CPU two fixed identification words and a read/write interrupt-enable word. It also keeps a network interrupt status word with one bit per line-card slot. Each slot has a pair of event inputs, one to set and one to clear. These update the slot's status bit, and the block raises one network interrupt line toward the CPU whenever any status bit is set.

The CPU reaches the registers over a plain synchronous bus. The bus carries a byte offset, a write strobe, a read strobe, write data and registered read data. The status word can be read at two offsets, and bus writes never change it. The enable word is storage only: it does not mask the interrupt line. Software uses the enable word for its own bookkeeping and reads the status word to find the slot that raised the interrupt.

Top module: `midplane_irq_regs`

## Requirements
- R1: A read at offset 0x00 returns 0x00000012. The upper nibble of the low byte holds the slot number (1) and the lower nibble holds the revision (2). A write to offset 0x00 changes neither this value nor any other register.
- R2: A read at offset 0x08 returns 0x0000001C. A write to offset 0x08 changes neither this value nor any other register.
- R3: Offset 0x10 holds a 32-bit enable word. A write stores the write data, and a later read returns the last value stored.
- R4: The status word is read at offset 0x18 and also at offset 0x1B, and both return the same value. Bus writes to either offset leave the status word unchanged.
- R5: A set event on slot N sets status bit N, and a clear event on slot N clears status bit N. Status bits of other slots do not change. Bit 0 carries the out-of-band control channel source and bit 1 carries the in-band control channel source.
- R6: If set and clear arrive for the same slot in the same cycle, the bit ends up set. Event effects become visible on the status word and on the interrupt line after the next rising clock edge.
- R7: The network interrupt output is high exactly when at least one status bit is set. The enable word does not gate it.
- R8: A read from any offset other than 0x00, 0x08, 0x10, 0x18 and 0x1B returns zero. A write to such an offset changes no register.
- R9: Read data is registered. It is valid in the cycle after the read strobe and is zero in any cycle that follows a cycle without a read strobe.
- R10: Reset (active low) clears the status word, the enable word and the read data, and holds the interrupt output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| busAddr | input | 8 | Register byte offset |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data, valid one cycle after busRdEn |
| slotSet | input | 32 | Per-slot set events, bit N for slot N |
| slotClr | input | 32 | Per-slot clear events, bit N for slot N |
| netIrq | output | 1 | Network interrupt to the CPU |

## Verification
The embedded assertions check the following on every clocked cycle:
- Each status bit obeys its own set and clear inputs, with set taking priority.
- A bit with no event holds its value, whatever happens on the bus.
- Any set event raises the interrupt line on the next cycle.
- An enable write lands exactly as written.
- Read data falls to zero after cycles without a read, and unmapped reads return zero.

The bench scenarios cover what needs particular values or sequences:
- The two constant words.
- The equality of the two status aliases.
- Writes to read-only and unmapped offsets.
- Setting the enable word while the interrupt line stays driven only by status.
- The line dropping once the last bit clears.

// File: rtl/midplane_irq_pkg.sv
package midplane_irq_pkg;

  // Decoded register selects and strobes passed from control to datapath
  typedef struct packed {
    logic selId;
    logic selIntCtl;
    logic selEnable;
    logic selStatus;
    logic wrEnable;
    logic rdStrobe;
  } regStrobes_t;

endpackage

// File: rtl/midplane_irq_ctrl.sv
module midplane_irq_ctrl
  import midplane_irq_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] ID_OFS     = 8'h00,
  parameter logic [ADDR_W-1:0] INTCTL_OFS = 8'h08,
  parameter logic [ADDR_W-1:0] ENABLE_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] STAT_OFS_A = 8'h18,
  parameter logic [ADDR_W-1:0] STAT_OFS_B = 8'h1B
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output regStrobes_t       strobes
);

  localparam int NUM_STAT_ALIAS = 2;
  localparam logic [NUM_STAT_ALIAS-1:0][ADDR_W-1:0] STAT_ALIASES = {STAT_OFS_B, STAT_OFS_A};

  logic [NUM_STAT_ALIAS-1:0] statHit;

  genvar a;
  generate
    for (a = 0; a < NUM_STAT_ALIAS; a++) begin : g_statAlias
      assign statHit[a] = (busAddr == STAT_ALIASES[a]);
    end
  endgenerate

  always_comb begin
    strobes           = '0;
    strobes.selId     = (busAddr == ID_OFS);
    strobes.selIntCtl = (busAddr == INTCTL_OFS);
    strobes.selEnable = (busAddr == ENABLE_OFS);
    strobes.selStatus = |statHit;
    // only the enable word is writable; all other writes are dropped here
    strobes.wrEnable  = busWrEn && (busAddr == ENABLE_OFS);
    strobes.rdStrobe  = busRdEn;
  end

endmodule

// File: rtl/midplane_irq_dp.sv
module midplane_irq_dp
  import midplane_irq_pkg::*;
#(
  parameter int                DATA_W       = 32,
  parameter int                NUM_SLOTS    = 32,
  parameter logic [DATA_W-1:0] ID_VALUE     = 32'h0000_0012,
  parameter logic [DATA_W-1:0] INTCTL_VALUE = 32'h0000_001C
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobes_t          strobes,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_SLOTS-1:0] slotSet,
  input  logic [NUM_SLOTS-1:0] slotClr,
  output logic [DATA_W-1:0]    rdData,
  output logic                 netIrq
);

  localparam int PAD_W = DATA_W - NUM_SLOTS;

  logic [DATA_W-1:0]    enableQ;
  logic [NUM_SLOTS-1:0] statusQ;
  logic [NUM_SLOTS-1:0] statusNext;
  logic [DATA_W-1:0]    statusWide;
  logic [DATA_W-1:0]    rdMux;
  logic [DATA_W-1:0]    rdDataQ;

  // Per-slot status bit: set has priority over clear
  genvar s;
  generate
    for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign statusNext[s] = slotSet[s] | (statusQ[s] & ~slotClr[s]);

      // R6
      set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
        slotSet[s] |=> statusQ[s]);
      // R5
      clear_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
        (slotClr[s] && !slotSet[s]) |=> !statusQ[s]);
      // R4
      hold_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
        (!slotSet[s] && !slotClr[s]) |=> $stable(statusQ[s]));
    end

    if (PAD_W > 0) begin : g_pad
      assign statusWide = {{PAD_W{1'b0}}, statusQ};
    end else begin : g_noPad
      assign statusWide = statusQ;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
    end else begin
      statusQ <= statusNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= '0;
    end else if (strobes.wrEnable) begin
      enableQ <= wrData;
    end
  end

  // R3
  enable_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEnable |=> (enableQ == $past(wrData)));

  // AND-OR read mux; unmapped offsets select nothing and yield zero
  always_comb begin
    rdMux = '0;
    rdMux |= {DATA_W{strobes.selId}}     & ID_VALUE;
    rdMux |= {DATA_W{strobes.selIntCtl}} & INTCTL_VALUE;
    rdMux |= {DATA_W{strobes.selEnable}} & enableQ;
    rdMux |= {DATA_W{strobes.selStatus}} & statusWide;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdDataQ <= '0;
    end else if (strobes.rdStrobe) begin
      rdDataQ <= rdMux;
    end else begin
      rdDataQ <= '0;
    end
  end

  assign rdData = rdDataQ;
  assign netIrq = |statusQ;

  // R9
  idle_rd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdStrobe |=> (rdData == '0));
  // R8
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdStrobe && !strobes.selId && !strobes.selIntCtl &&
     !strobes.selEnable && !strobes.selStatus) |=> (rdData == '0));
  // R1
  id_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdStrobe && strobes.selId) |=> (rdData == ID_VALUE));
  // R7
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|slotSet) |=> netIrq);

endmodule

// File: rtl/midplane_irq_regs.sv
module midplane_irq_regs
  import midplane_irq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int NUM_SLOTS = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  input  logic [NUM_SLOTS-1:0] slotSet,
  input  logic [NUM_SLOTS-1:0] slotClr,
  output logic                 netIrq
);

  regStrobes_t strobes;

  midplane_irq_ctrl #(
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobes (strobes)
  );

  midplane_irq_dp #(
    .DATA_W    (DATA_W),
    .NUM_SLOTS (NUM_SLOTS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (busWrData),
    .slotSet (slotSet),
    .slotClr (slotClr),
    .rdData  (busRdData),
    .netIrq  (netIrq)
  );

endmodule

// File: tb/midplane_irq_regs_tb.sv
module midplane_irq_regs_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] slotSet = '0;
  logic [31:0] slotClr = '0;
  logic        netIrq;

  always #2 clk = ~clk; // 250 MHz

  midplane_irq_regs u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .slotSet   (slotSet),
    .slotClr   (slotClr),
    .netIrq    (netIrq)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [31:0] expQ[$];
  string       tagQ[$];
  logic [31:0] modelStatus = '0;
  logic [31:0] modelEnable = '0;
  logic        rdEnDly = 1'b0;

  always @(posedge clk) rdEnDly <= busRdEn;

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Monitor: pops one expected item for each read issued in the prior cycle
  always @(negedge clk) begin
    if (rdEnDly) begin
      if (expQ.size() == 0) begin
        check(busRdData, 32'hDEAD_BEEF, "R9 unexpected read data");
      end else begin
        check(busRdData, expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  function automatic logic [31:0] expRead(input logic [7:0] addr);
    case (addr)
      8'h00:        return 32'h12;
      8'h08:        return 32'h1C;
      8'h10:        return modelEnable;
      8'h18, 8'h1B: return modelStatus;
      default:      return 32'h0;
    endcase
  endfunction

  task automatic busRead(input logic [7:0] addr, input string tag);
    busAddr = addr;
    busRdEn = 1'b1;
    expQ.push_back(expRead(addr));
    tagQ.push_back(tag);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic busWrite(input logic [7:0] addr, input logic [31:0] data);
    busAddr   = addr;
    busWrData = data;
    busWrEn   = 1'b1;
    if (addr == 8'h10) modelEnable = data;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic pulseEvents(input logic [31:0] setV, input logic [31:0] clrV);
    slotSet = setV;
    slotClr = clrV;
    modelStatus = (modelStatus & ~clrV) | setV;
    @(negedge clk);
    slotSet = '0;
    slotClr = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check({31'b0, netIrq}, 32'h0, "R10 irq in reset");
    check(busRdData, 32'h0, "R10 read data in reset");
    rstN = 1'b1;
    @(negedge clk);
    busRead(8'h10, "R10 enable after reset");
    busRead(8'h18, "R10 status after reset");

    // R1 / R2 constants, writes ignored
    busRead(8'h00, "R1 id word");
    busWrite(8'h00, 32'hFFFF_FFFF);
    busRead(8'h00, "R1 id after write");
    busRead(8'h08, "R2 int ctl word");
    busWrite(8'h08, 32'h0);
    busRead(8'h08, "R2 int ctl after write");
    busRead(8'h10, "R1 R2 enable untouched by ro writes");

    // R3 enable storage; R7 not affected by enable
    busWrite(8'h10, 32'hA5A5_5A5A);
    busRead(8'h10, "R3 enable readback");
    check({31'b0, netIrq}, 32'h0, "R7 enable does not raise irq");
    busWrite(8'h10, 32'h0000_0000);
    busRead(8'h10, "R3 enable cleared");

    // R5 / R7 set slot 0 with enable at zero
    pulseEvents(32'h1, 32'h0);
    check({31'b0, netIrq}, 32'h1, "R7 irq ungated by enable");
    busRead(8'h18, "R4 status at first alias");
    busRead(8'h1B, "R4 status at second alias");

    // R4 bus writes to status ignored
    busWrite(8'h18, 32'hFFFF_FFFF);
    busWrite(8'h1B, 32'h0);
    busRead(8'h18, "R4 status after writes");

    // R5 more slots, then clear one
    pulseEvents(32'h8000_0002, 32'h0);
    busRead(8'h1B, "R5 slots 0 1 31 set");
    pulseEvents(32'h0, 32'h1);
    busRead(8'h18, "R5 slot 0 cleared others kept");

    // R6 set wins same slot; mixed slots in one cycle
    pulseEvents(32'h20, 32'h20);
    busRead(8'h18, "R6 set wins on slot 5");
    pulseEvents(32'h100, 32'h2);
    busRead(8'h1B, "R6 set slot 8 clear slot 1 together");

    // R8 unmapped offsets
    busRead(8'h04, "R8 unmapped 0x04");
    busRead(8'h19, "R8 unmapped 0x19");
    busRead(8'hFF, "R8 unmapped 0xFF");
    busRead(8'h11, "R8 unmapped 0x11");
    busWrite(8'h20, 32'h1234_5678);
    busWrite(8'h14, 32'hFFFF_FFFF);
    busRead(8'h10, "R8 enable after unmapped writes");
    busRead(8'h18, "R8 status after unmapped writes");

    // R9 read data returns to zero after an idle cycle
    busRead(8'h00, "R9 read before idle");
    @(negedge clk);
    check(busRdData, 32'h0, "R9 zero after idle cycle");

    // R7 clear everything, line drops
    pulseEvents(32'h0, 32'hFFFF_FFFF);
    check({31'b0, netIrq}, 32'h0, "R7 irq low when status empty");
    busRead(8'h18, "R5 status empty");

    repeat (3) @(negedge clk);
    check(expQ.size(), 32'h0, "R9 all reads answered");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL R9 watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule